// File: doc/BRIEF.md
# MII Nibble Transmit Frame Serializer

This block takes the bytes of one Ethernet frame from an upstream valid/ready source and turns them into a stream of 4-bit nibbles for an MII-style transmit interface. It opens every frame with a fixed preamble and a start-of-frame delimiter. It then forwards the payload one nibble per clock, low half of each byte first. It can optionally fill a short frame with zero bytes up to a programmable minimum length, and it can optionally append a 32-bit frame check sequence. The transmit enable output stays high for exactly the nibbles that belong to the frame.

A frame begins when `in_valid` is seen while the block is idle. The source holds the first byte on the input until the block requests it. The block does not accept any byte during the preamble, the delimiter, padding or the check sequence. Inside the data phase it asks for one byte every second clock. The pad and check-sequence controls in force are those presented with the most recently accepted byte, so the values that come with the last byte decide how the frame ends. Carrier deferral, collision handling and descriptor management belong to other blocks.

Top module: `mii_tx_serializer`

## Requirements
- R1: While reset is asserted and whenever no frame is in progress, `tx_en` is 0, `txd` is 0 and `in_ready` is 0.
- R2: When `in_valid` is high in an idle cycle, `tx_en` rises on the next clock. The first 16 nibbles of the frame are fourteen 0x5 nibbles followed by 0x5 and then 0xD, which is preamble byte 0x55 seven times and then delimiter byte 0xD5.
- R3: Every byte goes out as two consecutive nibbles on consecutive clocks. Bits [3:0] go out first and bits [7:4] second.
- R4: `in_ready` is high only in the second nibble cycle of the delimiter and in the second nibble cycle of each data byte that was not flagged last. An accepted byte's low nibble appears on `txd` in the cycle after acceptance. With `in_valid` held high, a frame of N bytes sees `in_ready` high for exactly N cycles.
- R5: If the pad control is 1 and the data byte count is below `min_len`, 0x00 bytes follow the data until data plus pad equals `min_len`. If the count is already at or above `min_len`, no pad is added. The check sequence is not counted in this length.
- R6: If the check-sequence control is 1, four bytes follow the data and pad. They are the reflected CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF, result inverted) over data and pad, sent least significant byte first. For the bytes "123456789" the value is 0xCBF43926.
- R7: If the check-sequence control is 0, the frame ends after the last data or pad nibble.
- R8: `tx_en` stays high from the first preamble nibble through the final nibble and is low in the following cycle. Between two frames there is at least one cycle with `tx_en` low.
- R9: If `in_valid` is low in a cycle where `in_ready` is high, the frame ends as if the previously accepted byte had been flagged last. Padding and the check sequence then apply as normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one nibble per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| min_len | input | 16 | Minimum frame length in bytes, excluding the check sequence |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block accepts `in_data` at this edge |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final data byte of the frame |
| in_pad | input | 1 | Pad-to-minimum control for the frame |
| in_crc | input | 1 | Append-check-sequence control for the frame |
| tx_en | output | 1 | Transmit enable toward the PHY |
| txd | output | 4 | Transmit nibble toward the PHY |

## Verification
The end of the data phase is where two decisions meet in a single cycle. As the last data nibble leaves, the block must decide both whether padding starts and whether the check sequence starts. The bench provokes this with frames exactly one byte below, exactly at and well above the minimum length, each with padding and the check sequence enabled. It also ends a frame early by dropping `in_valid`. Each captured nibble stream is compared with a stream built in the bench from the requirements, including a check sequence computed independently and a known-answer vector.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_SFD,
        PH_DATA,
        PH_PAD,
        PH_FCS
    } phase_e;

    localparam logic [7:0]  PRE_BYTE       = 8'h55;
    localparam logic [7:0]  SFD_BYTE       = 8'hD5;
    localparam int          PRE_BYTES      = 7;
    localparam int          FCS_BYTES      = 4;
    localparam logic [31:0] CRC_SEED       = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB8_8320;

    typedef struct packed {
        phase_e     phase;
        logic [2:0] cnt;
        logic [7:0] cur;
        logic       hi;
        logic       last;
        logic       pad;
        logic       crc;
    } seq_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
    import mii_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = CRC_SEED;
        end else if (upd) begin
            crc_d = crc32_step(crc_q, din);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign fcs = ~crc_q;
endmodule

// File: rtl/mii_tx_len.sv
module mii_tx_len #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    input  logic [LEN_W-1:0] min_len,
    output logic             below
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic [LEN_W-1:0] len_d, len_q;

    always_comb begin
        len_d = len_q;
        if (clear) begin
            len_d = '0;
        end else if (inc && (len_q != LEN_MAX)) begin
            len_d = len_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else begin
            len_q <= len_d;
        end
    end

    assign below = (len_q < min_len);
endmodule

// File: rtl/mii_tx_nib.sv
module mii_tx_nib #(
    parameter int BYTE_W = 8
) (
    input  logic              active,
    input  logic              hi,
    input  logic [BYTE_W-1:0] cur,
    output logic [BYTE_W/2-1:0] txd
);
    localparam int NIB_W = BYTE_W / 2;

    always_comb begin
        if (!active) begin
            txd = '0;
        end else if (hi) begin
            txd = cur[BYTE_W-1:NIB_W];
        end else begin
            txd = cur[NIB_W-1:0];
        end
    end
endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer
    import mii_tx_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] min_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    input  logic             in_pad,
    input  logic             in_crc,
    output logic             tx_en,
    output logic [3:0]       txd
);
    localparam logic [2:0] PRE_LAST = 3'(PRE_BYTES - 1);
    localparam logic [2:0] FCS_LAST = 3'(FCS_BYTES - 1);

    seq_t        seq_d, seq_q;
    logic        crc_clear, crc_upd;
    logic [7:0]  crc_din;
    logic [31:0] fcs;
    logic        len_clear, len_inc, len_below;
    logic        active;
    logic [1:0]  fcs_idx;

    assign active   = (seq_q.phase != PH_IDLE);
    assign in_ready = seq_q.hi &&
                      ((seq_q.phase == PH_SFD) ||
                       ((seq_q.phase == PH_DATA) && !seq_q.last));
    assign fcs_idx  = seq_q.cnt[1:0] + 2'd1;

    always_comb begin
        seq_d     = seq_q;
        crc_clear = 1'b0;
        crc_upd   = 1'b0;
        crc_din   = 8'h00;
        len_clear = 1'b0;
        len_inc   = 1'b0;

        if (seq_q.phase == PH_IDLE) begin
            seq_d.cur = 8'h00;
            seq_d.hi  = 1'b0;
            if (in_valid) begin
                seq_d.phase = PH_PRE;
                seq_d.cnt   = 3'd0;
                seq_d.cur   = PRE_BYTE;
                seq_d.last  = 1'b0;
                seq_d.pad   = in_pad;
                seq_d.crc   = in_crc;
                crc_clear   = 1'b1;
                len_clear   = 1'b1;
            end
        end else if (!seq_q.hi) begin
            seq_d.hi = 1'b1;
        end else begin
            seq_d.hi = 1'b0;
            case (seq_q.phase)
                PH_PRE: begin
                    if (seq_q.cnt == PRE_LAST) begin
                        seq_d.phase = PH_SFD;
                        seq_d.cnt   = 3'd0;
                        seq_d.cur   = SFD_BYTE;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 3'd1;
                    end
                end
                PH_FCS: begin
                    if (seq_q.cnt == FCS_LAST) begin
                        seq_d.phase = PH_IDLE;
                        seq_d.cur   = 8'h00;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 3'd1;
                        seq_d.cur = fcs[8*fcs_idx +: 8];
                    end
                end
                default: begin
                    if (in_ready && in_valid) begin
                        seq_d.phase = PH_DATA;
                        seq_d.cur   = in_data;
                        seq_d.last  = in_last;
                        seq_d.pad   = in_pad;
                        seq_d.crc   = in_crc;
                        crc_upd     = 1'b1;
                        crc_din     = in_data;
                        len_inc     = 1'b1;
                    end else if (seq_q.pad && len_below) begin
                        seq_d.phase = PH_PAD;
                        seq_d.cur   = 8'h00;
                        crc_upd     = 1'b1;
                        crc_din     = 8'h00;
                        len_inc     = 1'b1;
                    end else if (seq_q.crc) begin
                        seq_d.phase = PH_FCS;
                        seq_d.cnt   = 3'd0;
                        seq_d.cur   = fcs[7:0];
                    end else begin
                        seq_d.phase = PH_IDLE;
                        seq_d.cur   = 8'h00;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, cnt: 3'd0, cur: 8'h00, hi: 1'b0,
                       last: 1'b0, pad: 1'b0, crc: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    mii_tx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .upd   (crc_upd),
        .din   (crc_din),
        .fcs   (fcs)
    );

    mii_tx_len #(.LEN_W(LEN_W)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (len_clear),
        .inc     (len_inc),
        .min_len (min_len),
        .below   (len_below)
    );

    mii_tx_nib #(.BYTE_W(8)) u_nib (
        .active (active),
        .hi     (seq_q.hi),
        .cur    (seq_q.cur),
        .txd    (txd)
    );

    assign tx_en = active;
endmodule

// File: rtl/mii_tx_serializer_chk.sv
module mii_tx_serializer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_data,
    input logic       tx_en,
    input logic [3:0] txd
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 4'h0) && !in_ready);

    a_r2_start_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && in_valid) |=> tx_en);

    a_r2_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 4'h5));

    a_r3_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (txd == $past(in_data[3:0])) ##1 (txd == $past(in_data[7:4], 2)));

    a_r4_ready_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_en && $past(tx_en));

    a_r4_ready_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);
endmodule

bind mii_tx_serializer mii_tx_serializer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .tx_en    (tx_en),
    .txd      (txd)
);

// File: tb/mii_tx_serializer_tb.sv
module mii_tx_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] min_len = 16'd60;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_pad = 1'b0;
    logic        in_crc = 1'b0;
    logic        tx_en;
    logic [3:0]  txd;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] pay [0:127];
    logic [3:0] got_q [$];
    logic [3:0] exp_q [$];
    int rdy_seen;

    always #5 clk = ~clk;

    mii_tx_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .min_len(min_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_pad(in_pad), .in_crc(in_crc),
        .tx_en(tx_en), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else r = r >> 1;
        end
        return r;
    endfunction

    task automatic build_expect(input int n, input bit pad, input bit crc, input int minl);
        logic [31:0] c = 32'hFFFFFFFF;
        int len = n;
        exp_q.delete();
        for (int i = 0; i < 15; i++) exp_q.push_back(4'h5);
        exp_q.push_back(4'hD);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(pay[i][3:0]);
            exp_q.push_back(pay[i][7:4]);
            c = ref_crc(c, pay[i]);
        end
        if (pad) begin
            while (len < minl) begin
                exp_q.push_back(4'h0);
                exp_q.push_back(4'h0);
                c = ref_crc(c, 8'h00);
                len++;
            end
        end
        if (crc) begin
            c = ~c;
            for (int i = 0; i < 4; i++) begin
                exp_q.push_back(c[8*i +: 4]);
                exp_q.push_back(c[8*i+4 +: 4]);
            end
        end
    endtask

    task automatic drive_bytes(input int n, input bit pad, input bit crc, input bit gap);
        int idx = 0;
        bit took;
        @(negedge clk);
        in_valid = 1'b1; in_data = pay[0]; in_last = (n == 1) && !gap;
        in_pad = pad; in_crc = crc;
        while (idx < n) begin
            took = in_ready;
            @(negedge clk);
            if (took) begin
                idx++;
                if (idx < n) begin
                    in_data = pay[idx];
                    in_last = (idx == n - 1) && !gap;
                end else begin
                    in_valid = 1'b0; in_last = 1'b0;
                end
            end
        end
    endtask

    task automatic capture();
        got_q.delete();
        rdy_seen = 0;
        @(negedge clk);
        while (!tx_en) @(negedge clk);
        while (tx_en) begin
            got_q.push_back(txd);
            if (in_ready) rdy_seen++;
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input string tag, input int n, input bit pad, input bit crc,
                             input int minl, input bit gap);
        int bad = 0;
        int first = -1;
        min_len = 16'(minl);
        build_expect(n, pad, crc, minl);
        fork
            drive_bytes(n, pad, crc, gap);
            capture();
        join
        check(tx_en == 1'b0, {tag, " R8 tx_en low after frame"}, tx_en, 0);
        check(got_q.size() == exp_q.size(), {tag, " R8 nibble count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            if (got_q[i] !== exp_q[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, {tag, " R2 R3 nibble stream"},
              (first < 0) ? 0 : got_q[first], (first < 0) ? 0 : exp_q[first]);
        check(rdy_seen == (gap ? n + 1 : n), {tag, " R4 ready cycles"}, rdy_seen, gap ? n + 1 : n);
        repeat (2) @(negedge clk);
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 128; i++) pay[i] = 8'(i * 37 + seed);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(tx_en == 0 && txd == 0 && in_ready == 0, "R1 in reset", {tx_en, txd, in_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_en == 0 && txd == 0 && in_ready == 0, "R1 idle after reset", {tx_en, txd, in_ready}, 0);
    endtask

    task automatic t_known_crc();
        logic [31:0] f;
        string s = "123456789";
        for (int i = 0; i < 9; i++) pay[i] = s[i];
        run_frame("R6 known", 9, 1'b0, 1'b1, 0, 1'b0);
        f = 32'h0;
        if (got_q.size() >= 8) begin
            for (int i = 0; i < 8; i++) f[4*i +: 4] = got_q[got_q.size() - 8 + i];
        end
        check(f == 32'hCBF43926, "R6 known-answer FCS", f, 32'hCBF43926);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        fill(3);   run_frame("R5 R6 short padded", 10, 1'b1, 1'b1, 60, 1'b0);
        fill(11);  run_frame("R5 long no pad", 70, 1'b1, 1'b1, 60, 1'b0);
        fill(29);  run_frame("R5 exactly min", 60, 1'b1, 1'b1, 60, 1'b0);
        fill(41);  run_frame("R5 one below min", 59, 1'b1, 1'b1, 60, 1'b0);
        fill(53);  run_frame("R7 no pad no crc", 5, 1'b0, 1'b0, 60, 1'b0);
        fill(67);  run_frame("R7 pad without crc", 3, 1'b1, 1'b0, 8, 1'b0);
        fill(79);  run_frame("R7 single byte", 1, 1'b0, 1'b0, 60, 1'b0);
        t_known_crc();
        fill(97);  run_frame("R9 early end", 4, 1'b0, 1'b1, 60, 1'b1);
        @(negedge clk);
        check(tx_en == 0 && txd == 0 && in_ready == 0, "R1 idle at end", {tx_en, txd, in_ready}, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule